// File: doc/BRIEF.md
# MDIO Management Interface Master

This block runs single-master clause-22 management cycles toward Ethernet PHYs. A request port takes a PHY address, a register address, a direction flag and write data in the cycle that `req_valid` is high and `req_ready` is high. The block then builds the whole serial frame by itself. It drives the management clock and data pins, and it samples the returned data on reads. It signals completion with a one-cycle `done` pulse and a 16-bit result.

The management clock is derived from the system clock. Each phase length is given in nanoseconds and converted to a whole number of system cycles, always rounded upward. A receive bit uses a longer high phase so that a slow PHY has time to present data. The data input passes through a configurable synchronizer before it is sampled.

A read can fail when the PHY does not pull the turnaround bit low. In that case the block keeps the clock running for a fixed number of extra receive bits, so that a confused PHY shifts out whatever it holds. The read then completes with all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Each frame begins with PRE_LEN (32 by default) bits of value 1, driven with `mdio_oe` high.
- R2: After the preamble the block drives start bits 0,1. It then drives the direction code: 1,0 when `req_read` is 1 and 0,1 when `req_read` is 0.
- R3: The 5-bit PHY address follows the direction code, and the 5-bit register address comes after it. Both are sent most significant bit first.
- R4: A write drives the turnaround 1,0 and then the 16 data bits, MSB first. It then releases `mdio_oe` and runs one more clock. A write therefore has 65 MDC rising edges, 64 of them driven.
- R5: A read releases `mdio_oe` after the register address, so 46 bits are driven. It then samples one turnaround bit. If that bit is 0, the block shifts in 16 data bits MSB first, runs one extra released clock, and returns the data (64 rising edges).
- R6: If the sampled turnaround bit is 1, the block clocks FLUSH_LEN (32) further receive bits, ignores their values, and returns 16'hFFFF (79 rising edges).
- R7: MDC phase lengths are ceil(ns × CLK_HZ / 1e9) system cycles. The low phase is 250 ns, the high phase of a driven bit is 250 ns, and the high phase of a released bit is 350 ns. At 50 MHz this gives 13, 13 and 18 cycles.
- R8: `mdio_o` and `mdio_oe` change only while MDC is low, at the falling edge that ends the previous bit. The output is therefore set up a full low phase before the rising edge.
- R9: When idle, MDC is low and `mdio_oe` is low. `busy` is high from acceptance until the `done` pulse, which lasts one cycle, and `req_ready` is low while busy. A request presented while busy is ignored.
- R10: A write completes with `rd_data` equal to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 16 | Result, valid from `done` onward |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data out toward the PHY |
| mdio_oe | output | 1 | Data output enable |
| mdio_i | input | 1 | Data in from the PHY |

## Verification
The hardest path to reach from the ports is the turnaround failure. It needs a PHY that leaves the line high exactly in the 47th bit slot and then behaves differently during the flush. The bench PHY model counts MDC rising edges per transaction. On selected reads it drives a 1 in the turnaround slot and 0 in every flush slot, so a design that took the flushed bits as data would return zero instead of all ones. The release-to-receive timing is covered by measuring every high and low phase against the driven or released state seen at the rising edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int ADDR_W  = 5;
   localparam int DATA_W  = 16;
   // start(2) + op(2) + phy + reg + turnaround(2) + data
   localparam int FRAME_W = 4 + 2 * ADDR_W + 2 + DATA_W;
   localparam int HDR_W   = 4 + 2 * ADDR_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SHIFT,
      ST_TA,
      ST_DATA,
      ST_FLUSH,
      ST_TAIL
   } mdm_state_e;
endpackage

// File: rtl/mdm_bit_timer.sv
module mdm_bit_timer #(
   parameter int LO_CYC   = 13,
   parameter int HI_TX    = 13,
   parameter int HI_RX    = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic rx_slot,
   output logic mdc,
   output logic bit_end
);
   localparam int MAXC = (LO_CYC > HI_TX) ? ((LO_CYC > HI_RX) ? LO_CYC : HI_RX)
                                          : ((HI_TX > HI_RX) ? HI_TX : HI_RX);
   localparam int TW = $clog2(MAXC + 1);

   logic [TW-1:0] cnt;
   logic          hi;
   logic [TW-1:0] hi_last;
   logic [TW-1:0] lo_last;

   assign lo_last = TW'(LO_CYC - 1);
   assign hi_last = rx_slot ? TW'(HI_RX - 1) : TW'(HI_TX - 1);
   assign bit_end = run && hi && (cnt == hi_last);
   assign mdc     = hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi  <= 1'b0;
         cnt <= '0;
      end else if (!run) begin
         hi  <= 1'b0;
         cnt <= '0;
      end else if (!hi) begin
         if (cnt == lo_last) begin
            hi  <= 1'b1;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == hi_last) begin
            hi  <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdm_frame_seq.sv
module mdm_frame_seq
   import mdm_pkg::*;
#(
   parameter int PRE_LEN   = 32,
   parameter int FLUSH_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [ADDR_W-1:0] req_phy,
   input  logic [ADDR_W-1:0] req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bit_end,
   input  logic              rx_bit,
   output logic              req_ready,
   output logic              run,
   output logic              rx_slot,
   output logic              tx_bit,
   output logic              tx_en,
   output logic              done,
   output logic [DATA_W-1:0] rd_data
);
   localparam int CMAX0 = (PRE_LEN > FLUSH_LEN) ? PRE_LEN : FLUSH_LEN;
   localparam int CMAX  = (CMAX0 > FRAME_W) ? CMAX0 : FRAME_W;
   localparam int CW    = (CMAX > 1) ? $clog2(CMAX) : 1;
   localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_LEN - 1);
   localparam logic [CW-1:0] FLUSH_LAST = CW'(FLUSH_LEN - 1);
   localparam logic [CW-1:0] HDR_LAST   = CW'(HDR_W - 1);
   localparam logic [CW-1:0] FRM_LAST   = CW'(FRAME_W - 1);
   localparam logic [CW-1:0] DAT_LAST   = CW'(DATA_W - 1);

   mdm_state_e          st;
   logic [CW-1:0]       cnt;
   logic                is_rd;
   logic [FRAME_W-1:0]  shreg;
   logic [DATA_W-1:0]   rsh;
   logic                done_q;
   logic [DATA_W-1:0]   rd_q;

   assign req_ready = (st == ST_IDLE);
   assign run       = (st != ST_IDLE);
   assign tx_en     = (st == ST_PRE) || (st == ST_SHIFT);
   assign tx_bit    = (st == ST_PRE) || ((st == ST_SHIFT) && shreg[FRAME_W-1]);
   assign rx_slot   = (st == ST_TA) || (st == ST_DATA) || (st == ST_FLUSH) || (st == ST_TAIL);
   assign done      = done_q;
   assign rd_data   = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         is_rd  <= 1'b0;
         shreg  <= '0;
         rsh    <= '0;
         done_q <= 1'b0;
         rd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               st    <= ST_PRE;
               cnt   <= '0;
               is_rd <= req_read;
               shreg <= {2'b01, req_read, ~req_read, req_phy, req_reg, 2'b10, req_wdata};
            end
            ST_PRE: if (bit_end) begin
               cnt <= cnt + 1'b1;
               if (cnt == PRE_LAST) begin
                  st  <= ST_SHIFT;
                  cnt <= '0;
               end
            end
            ST_SHIFT: if (bit_end) begin
               shreg <= {shreg[FRAME_W-2:0], 1'b0};
               cnt   <= cnt + 1'b1;
               if (cnt == (is_rd ? HDR_LAST : FRM_LAST)) begin
                  st  <= is_rd ? ST_TA : ST_TAIL;
                  cnt <= '0;
               end
            end
            ST_TA: if (bit_end) begin
               st  <= rx_bit ? ST_FLUSH : ST_DATA;
               cnt <= '0;
            end
            ST_DATA: if (bit_end) begin
               rsh <= {rsh[DATA_W-2:0], rx_bit};
               cnt <= cnt + 1'b1;
               if (cnt == DAT_LAST) begin
                  st  <= ST_TAIL;
                  cnt <= '0;
               end
            end
            ST_FLUSH: if (bit_end) begin
               cnt <= cnt + 1'b1;
               if (cnt == FLUSH_LAST) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  rd_q   <= '1;
               end
            end
            ST_TAIL: if (bit_end) begin
               st     <= ST_IDLE;
               done_q <= 1'b1;
               rd_q   <= is_rd ? rsh : '0;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdm_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int HALF_NS     = 250,
   parameter int RX_HI_NS    = 350,
   parameter int PRE_LEN     = 32,
   parameter int FLUSH_LEN   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_read,
   input  logic [ADDR_W-1:0] req_phy,
   input  logic [ADDR_W-1:0] req_reg,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam int KHZ      = CLK_HZ / 1000;
   localparam int HALF_CYC = (HALF_NS * KHZ + 999_999) / 1_000_000;
   localparam int RDHI_CYC = (RX_HI_NS * KHZ + 999_999) / 1_000_000;

   if (HALF_CYC < 1) begin : g_bad_clk
      $error("clock too slow or phase length zero");
   end
   if (RDHI_CYC <= SYNC_STAGES) begin : g_bad_sync
      $error("receive high phase shorter than input synchronizer");
   end
   if (PRE_LEN < 1 || FLUSH_LEN < 1) begin : g_bad_len
      $error("preamble and flush lengths must be positive");
   end

   logic run, rx_slot, bit_end, rx_bit, tx_bit, tx_en;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_bit = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq <= '1;
         else        sq <= (sq << 1) | SYNC_STAGES'(mdio_i);
      end
      assign rx_bit = sq[SYNC_STAGES-1];
   end

   mdm_bit_timer #(
      .LO_CYC (HALF_CYC),
      .HI_TX  (HALF_CYC),
      .HI_RX  (RDHI_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .rx_slot (rx_slot),
      .mdc     (mdc),
      .bit_end (bit_end)
   );

   mdm_frame_seq #(
      .PRE_LEN   (PRE_LEN),
      .FLUSH_LEN (FLUSH_LEN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_read  (req_read),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_wdata (req_wdata),
      .bit_end   (bit_end),
      .rx_bit    (rx_bit),
      .req_ready (req_ready),
      .run       (run),
      .rx_slot   (rx_slot),
      .tx_bit    (tx_bit),
      .tx_en     (tx_en),
      .done      (done),
      .rd_data   (rd_data)
   );

   assign busy    = run;
   assign mdio_o  = tx_bit;
   assign mdio_oe = tx_en;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk #(
   parameter int HI_TX = 13,
   parameter int HI_RX = 18
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic mdc,
   input logic mdio_o,
   input logic mdio_oe
);
   logic [15:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_cnt <= '0;
      else if (mdc) hi_cnt <= hi_cnt + 1'b1;
      else          hi_cnt <= '0;
   end

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R8
   setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R8
   release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdio_oe) |-> !mdc);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R7
   hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (hi_cnt == 16'(HI_TX) || hi_cnt == 16'(HI_RX)));
endmodule

bind mdio_mgmt_master mdm_chk #(
   .HI_TX (HALF_CYC),
   .HI_RX (RDHI_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
   localparam int HALF = (250 * 50_000 + 999_999) / 1_000_000;
   localparam int RDH  = (350 * 50_000 + 999_999) / 1_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_read = 1'b0;
   logic [4:0]  req_phy = '0;
   logic [4:0]  req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [15:0] rd_data;
   logic        busy;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int vectors = 0;
   int fails = 0;

   always #10 clk = ~clk;

   mdio_mgmt_master u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
      .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .busy(busy),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model state
   int          k = 0;
   int          ndrv = 0;
   int          nrel = 0;
   int          oe_gap = 0;
   logic [63:0] cap = '0;
   int          rises_total = 0;
   logic        ta_bad = 1'b0;
   logic [15:0] phy_data = '0;

   always @(posedge mdc) begin
      rises_total++;
      if (mdio_oe) begin
         cap = {cap[62:0], mdio_o};
         ndrv++;
         if (nrel > 0) oe_gap++;
      end else begin
         nrel++;
      end
      if (k == 46)                 mdio_i = ta_bad;
      else if (ta_bad && k > 46)   mdio_i = 1'b0;
      else if (k >= 47 && k <= 62) mdio_i = phy_data[62 - k];
      else                         mdio_i = 1'b1;
      k++;
   end

   // phase timing monitor
   logic mdc_prev = 1'b0;
   logic oe_rise = 1'b0;
   logic lo_valid = 1'b0;
   int   hi_run = 0;
   int   lo_run = 0;
   int   tim_err = 0;

   always @(negedge clk) begin
      if (mdc && !mdc_prev) begin
         if (lo_valid && lo_run != HALF) tim_err++;
         hi_run = 1;
         oe_rise = mdio_oe;
      end else if (!mdc && mdc_prev) begin
         if (hi_run != (oe_rise ? HALF : RDH)) tim_err++;
         lo_run = 1;
         lo_valid = 1'b1;
      end else if (mdc) begin
         hi_run++;
      end else begin
         lo_run++;
      end
      mdc_prev = mdc;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input bit bad, input bit poke);
      logic [15:0] got;
      logic [63:0] f;
      int          sh;
      while (!req_ready) @(negedge clk);
      k = 0; ndrv = 0; nrel = 0; oe_gap = 0; cap = '0; tim_err = 0; lo_valid = 1'b0;
      ta_bad = bad; phy_data = wd;
      req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         repeat (300) @(negedge clk);
         // R9 busy and not ready mid-transaction
         chk(busy && !req_ready, "R9", {busy, req_ready}, 2'b10);
         req_read = 1'b1; req_phy = ~phy; req_reg = ~rg; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (!done) @(negedge clk);
      got = rd_data;
      f = cap;
      sh = rd ? 0 : 18;
      // R1 preamble
      chk(((f >> (14 + sh)) & 64'hFFFF_FFFF) == 64'hFFFF_FFFF, "R1", (f >> (14 + sh)) & 64'hFFFF_FFFF, 64'hFFFF_FFFF);
      // R2 start and direction code
      chk(((f >> (10 + sh)) & 64'hF) == (rd ? 64'h6 : 64'h5), "R2", (f >> (10 + sh)) & 64'hF, rd ? 6 : 5);
      // R3 addresses
      chk(((f >> sh) & 64'h3FF) == {54'd0, phy, rg}, "R3", (f >> sh) & 64'h3FF, {phy, rg});
      if (!rd) begin
         // R4 turnaround, data, release and trailing clock
         chk((f & 64'h3FFFF) == {46'd0, 2'b10, wd}, "R4", f & 64'h3FFFF, {2'b10, wd});
         chk(ndrv == 64 && nrel == 1 && oe_gap == 0, "R4", {ndrv, nrel}, {32'd64, 32'd1});
         // R10
         chk(got == 16'h0000, "R10", got, 0);
      end else if (!bad) begin
         // R5
         chk(ndrv == 46 && nrel == 18 && oe_gap == 0, "R5", {ndrv, nrel}, {32'd46, 32'd18});
         chk(got == wd, "R5", got, wd);
      end else begin
         // R6
         chk(ndrv == 46 && nrel == 33 && oe_gap == 0, "R6", {ndrv, nrel}, {32'd46, 32'd33});
         chk(got == 16'hFFFF, "R6", got, 16'hFFFF);
      end
      // R7 phase lengths
      chk(tim_err == 0, "R7", tim_err, 0);
      @(negedge clk);
      // R9 back to idle
      chk(!busy && req_ready && !done && !mdc && !mdio_oe, "R9",
          {busy, req_ready, done, mdc, mdio_oe}, 5'b01000);
   endtask

   task automatic run_all();
      int r0;
      repeat (5) @(negedge clk);
      // R9 reset state
      chk(!mdc && !mdio_oe && !busy && !done && req_ready && rd_data == 0, "R9",
          {mdc, mdio_oe, busy, done, req_ready}, 5'b00001);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 12; i++) begin
         logic [4:0]  p;
         logic [4:0]  r;
         logic [15:0] d;
         p = 5'((i * 7) % 32);
         r = 5'((i * 13 + 5) % 32);
         d = 16'hA5C3 ^ 16'(i * 16'h1111) ^ 16'(i << 3);
         do_txn(1'b0, p, r, d, 1'b0, 1'b0);
         do_txn(1'b1, ~p, r, ~d, 1'b0, 1'b0);
      end
      // corner values
      do_txn(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b0, 1'b0);
      do_txn(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0, 1'b0);
      do_txn(1'b1, 5'd31, 5'd0, 16'h8001, 1'b0, 1'b0);
      // turnaround failures
      do_txn(1'b1, 5'd3, 5'd9, 16'h1234, 1'b1, 1'b0);
      do_txn(1'b1, 5'd30, 5'd17, 16'h0000, 1'b1, 1'b0);
      // request while busy must be ignored
      do_txn(1'b0, 5'd12, 5'd6, 16'h5A0F, 1'b0, 1'b1);
      r0 = rises_total;
      repeat (2000) @(negedge clk);
      // R9 ignored request started nothing
      chk(rises_total == r0 && !busy, "R9", rises_total - r0, 0);
      do_txn(1'b1, 5'd5, 5'd21, 16'hC0DE, 1'b1, 1'b0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (190_000) @(posedge clk);
            fails++;
            vectors++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule